// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block collects eight event sources from a disc-buffer controller and presents them to a byte-wide microcontroller register bus. The storage, front-end and error-correction logic signal events with single-cycle pulses. Each pulse sets a sticky flag. Software reads the flags, clears them by writing ones, and uses a mask register to choose which flags drive the single level interrupt line.

A flag is recorded whether or not its mask bit is set. Software can therefore poll for events it has chosen not to be interrupted by.

Two sources are formed inside the block. The first is an over-length source: a byte counter is cleared by a frame-start strobe, and the source fires when a single frame delivers more than 2352 bytes. The second is an aggregate source: it turns an external OR-reduced status level into an event on that level's rising edge.

Top module: `evt_irq_ctrl`

## Requirements
- R1: The mask register is at byte address 0xF0FB and the flag register is at 0xF0FC. The mask register takes the written byte. A read returns the addressed register on rdata_o in the same cycle. Any other address reads 0x00, and a write to it changes no state.
- R2: Flag bit positions: bit 0 is frame stored, bit 1 is last frame started, bit 2 is frame over length, bit 3 is header ready, bit 4 is correction complete, bit 5 is front-end receive ready, bit 6 is front-end transmit ready, and bit 7 is the aggregate secondary source.
- R3: An event pulse sets its flag at the next clock edge whatever its mask bit holds. The flag stays set until software clears it.
- R4: Writing the flag register clears each flag whose written bit is 1. Flags written with 0 keep their value.
- R5: When an event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R6: irq_o is a registered level. It is 1 in the cycle after one in which some flag and its mask bit are both 1, and 0 otherwise. It therefore drops one cycle after the last enabled flag is cleared or masked.
- R7: A frame-start strobe restarts the byte count. A byte strobe in the same cycle is counted as the first byte of the new frame.
- R8: The over-length flag (bit 2) is set by byte 2353 of a frame and not by byte 2352. It is set only once per frame, so it stays clear after software clears it, until a new frame exceeds the limit.
- R9: The aggregate flag (bit 7) is set on a 0-to-1 transition of its input level. While the level stays high, the flag does not set again.
- R10: During reset, flags, mask and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Register bus byte address |
| wr_i | input | 1 | Write strobe for addr_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| stored_i | input | 1 | Pulse: one frame fully stored |
| last_start_i | input | 1 | Pulse: last frame begins |
| hdr_rdy_i | input | 1 | Pulse: header or subcode-Q ready |
| ecc_done_i | input | 1 | Pulse: correction complete |
| rx_rdy_i | input | 1 | Pulse: front-end receive ready |
| tx_rdy_i | input | 1 | Pulse: front-end transmit ready |
| frame_start_i | input | 1 | Pulse: front-end frame begins |
| fe_byte_i | input | 1 | Pulse: one front-end byte delivered |
| aux_lvl_i | input | 1 | OR-reduced secondary status level |
| irq_o | output | 1 | Interrupt level to the microcontroller |

## Verification
A source event and a software clear of the same flag can land in one cycle. The bench provokes this by pulsing the frame-stored source while the flag register is written with bit 0 set, and it expects the flag to read back as 1.

A frame start and a byte strobe can also coincide. The bench drives both together and expects the over-length flag to appear only when the 2353rd byte counted from that strobe arrives.

A behavioural reference model is compared with irq_o and the addressed register on every cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned N_SRC  = 8;
  localparam int unsigned FRAME_LIMIT = 2352;

  localparam logic [ADDR_W-1:0] MASK_ADDR = 16'hF0FB;
  localparam logic [ADDR_W-1:0] FLAG_ADDR = 16'hF0FC;

  // flag bit positions (software decodes these)
  localparam int unsigned B_STORED = 0;
  localparam int unsigned B_LAST   = 1;
  localparam int unsigned B_OVLEN  = 2;
  localparam int unsigned B_HDR    = 3;
  localparam int unsigned B_ECC    = 4;
  localparam int unsigned B_RX     = 5;
  localparam int unsigned B_TX     = 6;
  localparam int unsigned B_AUX    = 7;
endpackage

// File: rtl/evt_len_mon.sv
module evt_len_mon #(
  parameter int unsigned LIMIT = 2352
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic byte_i,
  output logic over_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 2);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  // fires on the first byte past the limit; saturation stops repeats
  assign over_o = byte_i & ~start_i & (cnt_q == LIM_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= {{(CNT_W-1){1'b0}}, byte_i};
    end else if (byte_i && cnt_q != SAT_C) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/evt_rise_det.sv
module evt_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_d_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] mask_q;
  logic         irq_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_d_i;
      irq_q <= |(flag_q & mask_q);
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned LIMIT = FRAME_LIMIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              stored_i,
  input  logic              last_start_i,
  input  logic              hdr_rdy_i,
  input  logic              ecc_done_i,
  input  logic              rx_rdy_i,
  input  logic              tx_rdy_i,
  input  logic              frame_start_i,
  input  logic              fe_byte_i,
  input  logic              aux_lvl_i,
  output logic              irq_o
);
  logic             sel_mask, sel_flag;
  logic             ovlen_evt, aux_evt;
  logic [N_SRC-1:0] set_vec, clr_vec;
  logic [N_SRC-1:0] flag_q, mask_q;

  assign sel_mask = (addr_i == MASK_ADDR);
  assign sel_flag = (addr_i == FLAG_ADDR);

  evt_len_mon #(.LIMIT(LIMIT)) u_len (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(frame_start_i),
    .byte_i (fe_byte_i),
    .over_o (ovlen_evt)
  );

  evt_rise_det u_aux (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (aux_lvl_i),
    .rise_o(aux_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[B_STORED] = stored_i;
    set_vec[B_LAST]   = last_start_i;
    set_vec[B_OVLEN]  = ovlen_evt;
    set_vec[B_HDR]    = hdr_rdy_i;
    set_vec[B_ECC]    = ecc_done_i;
    set_vec[B_RX]     = rx_rdy_i;
    set_vec[B_TX]     = tx_rdy_i;
    set_vec[B_AUX]    = aux_evt;
  end

  assign clr_vec = (wr_i && sel_flag) ? wdata_i[N_SRC-1:0] : '0;

  evt_flag_bank #(.N(N_SRC)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .mask_we_i(wr_i && sel_mask),
    .mask_d_i (wdata_i[N_SRC-1:0]),
    .flag_o   (flag_q),
    .mask_o   (mask_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_mask)      rdata_o[N_SRC-1:0] = mask_q;
    else if (sel_flag) rdata_o[N_SRC-1:0] = flag_q;
  end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
  import evt_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              fe_byte_i,
  input logic [N_SRC-1:0]  set_i,
  input logic [N_SRC-1:0]  flag_i,
  input logic [N_SRC-1:0]  mask_i,
  input logic              irq_o
);
  logic flag_wr, mask_wr;
  assign flag_wr = wr_i && (addr_i == FLAG_ADDR);
  assign mask_wr = wr_i && (addr_i == MASK_ADDR);

  p_mask_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr |=> mask_i == $past(wdata_i[N_SRC-1:0]));

  p_event_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_i & $past(set_i)) == $past(set_i)));

  p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr |=> ((flag_i & $past(wdata_i[N_SRC-1:0]) & ~$past(set_i)) == '0));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_wr && set_i == '0) |=> $stable(flag_i));

  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_wr && ((set_i & wdata_i[N_SRC-1:0]) != '0))
      |=> ((flag_i & $past(set_i)) == $past(set_i)));

  p_irq_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(flag_i & mask_i)));

  p_ovlen_byte_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i[B_OVLEN]) |-> $past(fe_byte_i));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .wdata_i  (wdata_i),
  .fe_byte_i(fe_byte_i),
  .set_i    (set_vec),
  .flag_i   (flag_q),
  .mask_i   (mask_q),
  .irq_o    (irq_o)
);

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_MASK = 16'hF0FB;
  localparam logic [15:0] A_FLAG = 16'hF0FC;
  localparam int LIM = 2352;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic stored = 0, last_st = 0, hdr = 0, ecc = 0, rx = 0, tx = 0;
  logic fstart = 0, fbyte = 0, aux = 0;
  logic irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R10";

  // reference model state
  logic [7:0] m_flag = '0, m_mask = '0;
  logic m_irq = 1'b0, m_aux = 1'b0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_ctrl i_evt_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .stored_i(stored), .last_start_i(last_st), .hdr_rdy_i(hdr),
    .ecc_done_i(ecc), .rx_rdy_i(rx), .tx_rdy_i(tx), .frame_start_i(fstart),
    .fe_byte_i(fbyte), .aux_lvl_i(aux), .irq_o(irq)
  );

  always @(posedge clk) begin
    logic [7:0] setv, clrv;
    if (!rst_n) begin
      m_flag = '0; m_mask = '0; m_irq = 0; m_aux = 0; m_cnt = 0;
    end else begin
      setv = {aux && !m_aux, tx, rx, ecc, hdr,
              fbyte && !fstart && m_cnt == LIM, last_st, stored};
      clrv = (wr && addr == A_FLAG) ? wdata : 8'h00;
      m_irq = (m_flag & m_mask) != 0;
      m_flag = (m_flag & ~clrv) | setv;
      if (wr && addr == A_MASK) m_mask = wdata;
      if (fstart) m_cnt = fbyte ? 1 : 0;
      else if (fbyte && m_cnt <= LIM) m_cnt = m_cnt + 1;
      m_aux = aux;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(logic [15:0] a);
    if (a == A_MASK) return m_mask;
    if (a == A_FLAG) return m_flag;
    return 8'h00;
  endfunction

  // one clock; ends at the falling edge and compares with the model
  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/2);
    chk({cur_req, " irq R6"}, {7'b0, irq}, {7'b0, m_irq});
    chk({cur_req, " rdata"}, rdata, model_rd(addr));
  endtask

  task automatic idle();
    wr = 0; wdata = 0; stored = 0; last_st = 0; hdr = 0; ecc = 0;
    rx = 0; tx = 0; fstart = 0; fbyte = 0; addr = A_FLAG;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    addr = a; wr = 0; #1; d = rdata;
  endtask

  task automatic wreg(logic [15:0] a, logic [7:0] d);
    addr = a; wr = 1; wdata = d; step(); idle();
  endtask

  task automatic bytes(int n);
    for (int i = 0; i < n; i++) begin fbyte = 1; step(); end
    fbyte = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    idle();
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    rd(A_FLAG, d); chk("R10 flag", d, 8'h00);
    rd(A_MASK, d); chk("R10 mask", d, 8'h00);
    chk("R10 irq", {7'b0, irq}, 8'h00);
    rst_n = 1; step();

    // masked event still recorded
    cur_req = "R3";
    ecc = 1; step(); idle(); step();
    rd(A_FLAG, d); chk("R3 masked ecc flag", d, 8'h10);
    chk("R6 irq stays low while masked", {7'b0, irq}, 8'h00);

    // unmask -> irq one cycle later
    cur_req = "R6";
    wreg(A_MASK, 8'h10);
    rd(A_MASK, d); chk("R1 mask readback", d, 8'h10);
    chk("R6 irq not yet", {7'b0, irq}, 8'h00);
    step(); chk("R6 irq asserted", {7'b0, irq}, 8'h01);

    // write 0 keeps, write 1 clears
    cur_req = "R4";
    wreg(A_FLAG, 8'h00);
    rd(A_FLAG, d); chk("R4 write zero keeps", d, 8'h10);
    wreg(A_FLAG, 8'h10);
    rd(A_FLAG, d); chk("R4 write one clears", d, 8'h00);
    chk("R6 irq still high", {7'b0, irq}, 8'h01);
    step(); chk("R6 irq dropped", {7'b0, irq}, 8'h00);

    // masking drops irq
    hdr = 1; wreg(A_MASK, 8'h08); step(); step();
    chk("R6 irq on hdr", {7'b0, irq}, 8'h01);
    wreg(A_MASK, 8'h00); step();
    chk("R6 irq masked off", {7'b0, irq}, 8'h00);
    wreg(A_FLAG, 8'hFF);

    // set wins over same-cycle clear
    cur_req = "R5";
    stored = 1; wreg(A_FLAG, 8'h01);
    rd(A_FLAG, d); chk("R5 set beats clear", d, 8'h01);
    wreg(A_FLAG, 8'h01);
    rd(A_FLAG, d); chk("R5 later clear", d, 8'h00);

    // other address ignored
    cur_req = "R1";
    wreg(16'hF0FD, 8'hFF); wreg(16'hF0FA, 8'hFF);
    rd(16'hF0FD, d); chk("R1 unmapped reads zero", d, 8'h00);
    rd(A_MASK, d); chk("R1 mask untouched", d, 8'h00);
    rd(A_FLAG, d); chk("R1 flags untouched", d, 8'h00);

    // bit map
    cur_req = "R2";
    stored = 1; step(); idle(); rd(A_FLAG, d); chk("R2 bit0 stored", d, 8'h01); wreg(A_FLAG, 8'hFF);
    last_st = 1; step(); idle(); rd(A_FLAG, d); chk("R2 bit1 last", d, 8'h02); wreg(A_FLAG, 8'hFF);
    hdr = 1; step(); idle(); rd(A_FLAG, d); chk("R2 bit3 hdr", d, 8'h08); wreg(A_FLAG, 8'hFF);
    rx = 1; step(); idle(); rd(A_FLAG, d); chk("R2 bit5 rx", d, 8'h20); wreg(A_FLAG, 8'hFF);
    tx = 1; step(); idle(); rd(A_FLAG, d); chk("R2 bit6 tx", d, 8'h40); wreg(A_FLAG, 8'hFF);

    // frame length
    cur_req = "R8";
    fstart = 1; step(); idle();
    bytes(LIM);
    rd(A_FLAG, d); chk("R8 no flag at 2352", d, 8'h00);
    bytes(1);
    rd(A_FLAG, d); chk("R8 flag at 2353", d, 8'h04);
    wreg(A_FLAG, 8'h04);
    bytes(5);
    rd(A_FLAG, d); chk("R8 once per frame", d, 8'h00);

    cur_req = "R7";
    fstart = 1; fbyte = 1; step(); idle();
    bytes(LIM - 1);
    rd(A_FLAG, d); chk("R7 start byte counted, 2352 total", d, 8'h00);
    bytes(1);
    rd(A_FLAG, d); chk("R7 flag on byte 2353 incl start", d, 8'h04);
    wreg(A_FLAG, 8'hFF);

    // aggregate edge
    cur_req = "R9";
    aux = 1; step();
    rd(A_FLAG, d); chk("R9 rising edge sets", d, 8'h80);
    wreg(A_FLAG, 8'h80); step();
    rd(A_FLAG, d); chk("R9 high level does not reset flag", d, 8'h00);
    aux = 0; step(); aux = 1; step();
    rd(A_FLAG, d); chk("R9 second edge sets", d, 8'h80);
    aux = 0; wreg(A_FLAG, 8'hFF);

    repeat (3) step();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule